// File: doc/BRIEF.md
# Power-Good Window and Overvoltage Threshold Supervisor

This block sits beside the output-voltage sequencer of a multi-phase core regulator. It turns three digital comparator results into a power-good signal and a sticky overvoltage flag. The comparators report whether the output is below the lower window edge, above the upper window edge, or above the overvoltage limit. The block also tells the sequencer which overvoltage reference the limit comparator should use: a fixed level, or the tracked target voltage.

Whenever the sequencer reports a voltage move, both window edges are blanked and power-good is frozen. Once the sequencer signals that the slew target has arrived, a settle timer of `SETTLE_CYC` clocks runs. When it expires, the lower edge is armed again. The upper edge is armed only while the regulator runs in forced-PWM mode. In pulse-skipping mode the upper edge stays blanked, and the `upper_armed` output lets the clock-enable supervisor blank its matching edge. When the regulator enters pulse-skipping, the overvoltage reference moves to the fixed level. It returns to tracking once the regulation loop reports that the output is in regulation, or when the regulator leaves pulse-skipping. Driving `en` low (shutdown) forces power-good low in the same cycle and clears all state on the next edge.

Top module: `pwrgood_supervisor`

## Requirements
- R1: While `en` is low, `pwr_good` is 0 in the same cycle, without waiting for a clock edge. On the next edge, `lower_armed`, `ovp_fault` and `ovp_fixed_sel` clear to 0.
- R2: A cycle with `trans_active` high disarms the lower edge at the next edge and cancels a running settle timer. `pwr_good` keeps its value across every edge at which the lower edge is disarmed or `trans_active` is high, provided `en` is high.
- R3: A `target_reached` pulse sampled at edge T, with no `trans_active`, sets `lower_armed` to 1 at edge T+`SETTLE_CYC`. A further `target_reached` pulse restarts the count from zero.
- R4: `upper_armed` is 1 only while `lower_armed` is 1 and `skip_mode` is 0 (0 = forced-PWM, 1 = pulse-skipping).
- R5: At an edge with `en` high, the lower edge armed and `trans_active` low, power-good becomes 0 if `under_lo` is 1, or if `over_hi` is 1 while `upper_armed` is 1. Otherwise it becomes 1.
- R6: An edge at which `skip_mode` is 1 after being 0 at the previous edge sets `ovp_fixed_sel` to 1 (1 = fixed reference, 0 = tracked target).
- R7: While `ovp_fixed_sel` is 1, an edge with `in_reg` high, or an edge with `skip_mode` low, returns `ovp_fixed_sel` to 0. Skip entry takes priority over `in_reg` at the same edge.
- R8: An edge with `en` high and `ovp_over` high sets `ovp_fault`. The flag then stays 1 until shutdown or reset.
- R9: After a synchronous reset (`rst_n` low at an edge), all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Regulator enable; low means shutdown |
| skip_mode | input | 1 | 1 = pulse-skipping, 0 = forced-PWM |
| trans_active | input | 1 | Sequencer is moving the target voltage |
| target_reached | input | 1 | One-cycle pulse: slew target has arrived |
| in_reg | input | 1 | Regulation loop reports the output is in regulation |
| under_lo | input | 1 | Output is below the lower window edge |
| over_hi | input | 1 | Output is above the upper window edge |
| ovp_over | input | 1 | Output is above the currently selected overvoltage limit |
| pwr_good | output | 1 | Power-good indication |
| lower_armed | output | 1 | Lower window edge is enabled |
| upper_armed | output | 1 | Upper window edge is enabled; also used to blank the clock-enable edge |
| ovp_fixed_sel | output | 1 | 1 = limit comparator uses the fixed level, 0 = tracked target |
| ovp_fault | output | 1 | Latched overvoltage flag |

## Verification
A settle counter that is off by one shows up as `lower_armed` rising one cycle early or late after the target pulse. From then on, `pwr_good` follows `under_lo` from the wrong cycle. A stale skip-mode history shows up at the first edge after skip entry, with `ovp_fixed_sel` failing to rise. A stuck or forgotten overvoltage flag is visible on `ovp_fault` at the edge after the comparator pulse, or at the edge after shutdown. The behavioural model in the bench compares every output at every cycle, so any such error is reported within one clock of its first effect at the ports.

// File: rtl/pgsup_pkg.sv
// Package: shared types for the power-good supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package pgsup_pkg;
    // Which reference the overvoltage comparator is told to use
    typedef enum logic {
        OVP_TRACK = 1'b0,
        OVP_FIXED = 1'b1
    } ovp_sel_e;
endpackage

// File: rtl/pgsup_settle_timer.sv
// Module: settle timer that re-arms the lower window edge.
// What it does: clears the arm on any transition cycle. On a target pulse it
// counts SETTLE_CYC clocks, then arms the lower window edge.
// Assumes: target_reached is a single-cycle pulse; SETTLE_CYC >= 1.
module pgsup_settle_timer #(
    parameter int SETTLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic trans_active,
    input  logic target_reached,
    output logic lower_armed
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic          pend_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Purpose: blanking on transitions, settle count after the target pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (trans_active) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (target_reached) begin
            pend_q  <= 1'b1;
            cnt_q   <= '0;
        end else if (pend_q) begin
            if (cnt_q == LAST) begin
                pend_q  <= 1'b0;
                armed_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lower_armed = armed_q;
endmodule

// File: rtl/pgsup_window.sv
// Module: power-good window evaluator.
// What it does: registers the power-good state from the armed window edges.
// It holds that state while the window is blanked or a move is in progress.
// Assumes: the arm inputs come from registers; shutdown gating is done at the top.
module pgsup_window (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lower_armed,
    input  logic upper_armed,
    input  logic trans_active,
    input  logic under_lo,
    input  logic over_hi,
    output logic pg_q
);
    logic violate;

    // Purpose: any armed edge currently violated
    always_comb begin
        violate = (lower_armed & under_lo) | (upper_armed & over_hi);
    end

    // Purpose: update power-good only while the window is live
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pg_q <= 1'b0;
        end else if (lower_armed && !trans_active) begin
            pg_q <= ~violate;
        end
    end
endmodule

// File: rtl/pgsup_ovp_ctl.sv
// Module: overvoltage reference selector and sticky fault flag.
// What it does: selects the fixed reference on skip entry and returns to
// tracking on in-regulation or skip exit. Latches an overvoltage event.
// Assumes: ovp_over already compares against the reference selected here.
module pgsup_ovp_ctl
    import pgsup_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     skip_mode,
    input  logic     in_reg,
    input  logic     ovp_over,
    output ovp_sel_e sel,
    output logic     fault
);
    logic     skip_q;
    ovp_sel_e sel_q;
    logic     fault_q;

    // Purpose: remember the previous mode to detect skip entry
    always_ff @(posedge clk) begin
        if (!rst_n || !en) skip_q <= 1'b0;
        else               skip_q <= skip_mode;
    end

    // Purpose: reference selection, skip entry taking priority
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            sel_q <= OVP_TRACK;
        end else if (skip_mode && !skip_q) begin
            sel_q <= OVP_FIXED;
        end else if (!skip_mode || in_reg) begin
            sel_q <= OVP_TRACK;
        end
    end

    // Purpose: sticky overvoltage flag, cleared only by shutdown or reset
    always_ff @(posedge clk) begin
        if (!rst_n || !en) fault_q <= 1'b0;
        else if (ovp_over) fault_q <= 1'b1;
    end

    assign sel   = sel_q;
    assign fault = fault_q;
endmodule

// File: rtl/pwrgood_supervisor.sv
// Module: power-good and overvoltage threshold supervisor (top).
// What it does: joins the settle timer, the window evaluator and the
// overvoltage control. Gates power-good with the enable so that it drops
// at once in shutdown.
// Assumes: all inputs are synchronous to clk.
module pwrgood_supervisor
    import pgsup_pkg::*;
#(
    parameter int SETTLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic skip_mode,
    input  logic trans_active,
    input  logic target_reached,
    input  logic in_reg,
    input  logic under_lo,
    input  logic over_hi,
    input  logic ovp_over,
    output logic pwr_good,
    output logic lower_armed,
    output logic upper_armed,
    output logic ovp_fixed_sel,
    output logic ovp_fault
);
    logic     lo_arm;
    logic     hi_arm;
    logic     pg_q;
    ovp_sel_e sel;

    pgsup_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .en             (en),
        .trans_active   (trans_active),
        .target_reached (target_reached),
        .lower_armed    (lo_arm)
    );

    // Purpose: upper edge is live only in forced-PWM with the lower edge armed
    always_comb begin
        hi_arm = lo_arm & ~skip_mode;
    end

    pgsup_window u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .lower_armed  (lo_arm),
        .upper_armed  (hi_arm),
        .trans_active (trans_active),
        .under_lo     (under_lo),
        .over_hi      (over_hi),
        .pg_q         (pg_q)
    );

    pgsup_ovp_ctl u_ovp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .skip_mode (skip_mode),
        .in_reg    (in_reg),
        .ovp_over  (ovp_over),
        .sel       (sel),
        .fault     (ovp_fault)
    );

    // Purpose: drive the outputs; shutdown forces power-good low with no delay
    always_comb begin
        pwr_good      = en & pg_q;
        lower_armed   = lo_arm;
        upper_armed   = hi_arm;
        ovp_fixed_sel = (sel == OVP_FIXED);
    end
endmodule

// File: rtl/pwrgood_supervisor_chk.sv
// Module: property checker for pwrgood_supervisor, attached by bind.
// Assumes: observes only the top-level ports.
module pwrgood_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic skip_mode,
    input logic trans_active,
    input logic ovp_over,
    input logic pwr_good,
    input logic lower_armed,
    input logic upper_armed,
    input logic ovp_fixed_sel,
    input logic ovp_fault
);
    assert_shdn_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!lower_armed && !ovp_fault && !ovp_fixed_sel));

    assert_trans_blanks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trans_active) |=> !lower_armed);

    assert_pg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (!lower_armed || trans_active)) |=> (!en || $stable(pwr_good)));

    assert_arm_not_in_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lower_armed) |-> !$past(trans_active));

    assert_upper_blank_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_mode || !lower_armed) |-> !upper_armed);

    assert_skip_entry_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $rose(skip_mode)) |=> ovp_fixed_sel);

    assert_fault_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ovp_over) |=> ovp_fault);

    assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ovp_fault) |=> ovp_fault);
endmodule

bind pwrgood_supervisor pwrgood_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .skip_mode     (skip_mode),
    .trans_active  (trans_active),
    .ovp_over      (ovp_over),
    .pwr_good      (pwr_good),
    .lower_armed   (lower_armed),
    .upper_armed   (upper_armed),
    .ovp_fixed_sel (ovp_fixed_sel),
    .ovp_fault     (ovp_fault)
);

// File: tb/pwrgood_supervisor_bench.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module pwrgood_supervisor_bench;
    localparam int S = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, skip_mode = 1'b0, trans_active = 1'b0, target_reached = 1'b0;
    logic in_reg = 1'b0, under_lo = 1'b0, over_hi = 1'b0, ovp_over = 1'b0;
    logic pwr_good, lower_armed, upper_armed, ovp_fixed_sel, ovp_fault;

    int checks = 0;
    int errors = 0;
    bit comparing = 1'b0;

    // model state
    int m_lo = 0, m_pend = 0, m_cnt = 0, m_pg = 0, m_fix = 0, m_fault = 0, m_skd = 0;

    always #5 clk = ~clk;

    pwrgood_supervisor #(.SETTLE_CYC(S)) u_pwrgood_supervisor (
        .clk(clk), .rst_n(rst_n), .en(en), .skip_mode(skip_mode),
        .trans_active(trans_active), .target_reached(target_reached),
        .in_reg(in_reg), .under_lo(under_lo), .over_hi(over_hi),
        .ovp_over(ovp_over), .pwr_good(pwr_good), .lower_armed(lower_armed),
        .upper_armed(upper_armed), .ovp_fixed_sel(ovp_fixed_sel),
        .ovp_fault(ovp_fault)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, updated from the values sampled at each edge
    always @(posedge clk) begin
        int lo_old;
        lo_old = m_lo;
        if (!rst_n || !en) begin
            m_lo = 0; m_pend = 0; m_cnt = 0; m_pg = 0; m_fix = 0; m_fault = 0; m_skd = 0;
        end else begin
            if (lo_old == 1 && !trans_active)
                m_pg = (under_lo || (over_hi && !skip_mode)) ? 0 : 1;
            if (trans_active) begin
                m_lo = 0; m_pend = 0; m_cnt = 0;
            end else if (target_reached) begin
                m_pend = 1; m_cnt = 0;
            end else if (m_pend == 1) begin
                m_cnt++;
                if (m_cnt == S) begin m_lo = 1; m_pend = 0; end
            end
            if (skip_mode && m_skd == 0) m_fix = 1;
            else if (!skip_mode || in_reg) m_fix = 0;
            m_skd = skip_mode ? 1 : 0;
            if (ovp_over) m_fault = 1;
        end
    end

    // compare every output at each falling edge
    always @(negedge clk) begin
        if (comparing) begin
            chk(!en ? "R1" : ((m_lo == 0 || trans_active) ? "R2" : "R5"),
                pwr_good, en && (m_pg == 1));
            chk("R3", lower_armed, m_lo == 1);
            chk("R4", upper_armed, (m_lo == 1) && !skip_mode);
            chk(m_fix == 1 ? "R6" : "R7", ovp_fixed_sel, m_fix == 1);
            chk("R8", ovp_fault, m_fault == 1);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
            target_reached = 1'b0;
        end
    endtask

    task automatic pulse_target();
        @(negedge clk); #2;
        target_reached = 1'b1;
        @(negedge clk); #2;
        target_reached = 1'b0;
    endtask

    // watchdog
    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(3);
        // R9 reset state
        chk("R9", pwr_good, 1'b0);
        chk("R9", lower_armed, 1'b0);
        chk("R9", upper_armed, 1'b0);
        chk("R9", ovp_fixed_sel, 1'b0);
        chk("R9", ovp_fault, 1'b0);
        rst_n = 1'b1; en = 1'b1;
        comparing = 1'b1;
        cyc(4);
        // R3: arm exactly S edges after the target pulse
        pulse_target();
        cyc(S - 3);
        chk("R3", lower_armed, 1'b0);
        cyc(4);
        chk("R3", lower_armed, 1'b1);
        // R5: window live
        cyc(2);
        chk("R5", pwr_good, 1'b1);
        under_lo = 1'b1; cyc(2); under_lo = 1'b0; cyc(2);
        over_hi = 1'b1; cyc(2);
        chk("R5", pwr_good, 1'b0);
        over_hi = 1'b0; cyc(2);
        // R4/R6: skip entry blanks upper, fixed reference
        skip_mode = 1'b1; over_hi = 1'b1; cyc(3);
        chk("R4", upper_armed, 1'b0);
        chk("R6", ovp_fixed_sel, 1'b1);
        chk("R4", pwr_good, 1'b1);
        // R7: in-regulation returns to tracking
        in_reg = 1'b1; cyc(2); in_reg = 1'b0;
        chk("R7", ovp_fixed_sel, 1'b0);
        over_hi = 1'b0;
        skip_mode = 1'b0; cyc(2); skip_mode = 1'b1; cyc(2);
        skip_mode = 1'b0; cyc(2);
        chk("R7", ovp_fixed_sel, 1'b0);
        // R2: transition freezes power-good while the window violates
        trans_active = 1'b1; under_lo = 1'b1; cyc(5);
        chk("R2", pwr_good, 1'b1);
        trans_active = 1'b0; cyc(5);
        chk("R2", pwr_good, 1'b1);
        // R3 restart: second pulse mid-count
        pulse_target(); cyc(S / 2); pulse_target(); cyc(S - 4);
        chk("R3", lower_armed, 1'b0);
        cyc(6);
        chk("R3", lower_armed, 1'b1);
        cyc(2); under_lo = 1'b0; cyc(3);
        // transition cancels a running count
        pulse_target(); cyc(5);
        trans_active = 1'b1; cyc(1); trans_active = 1'b0; cyc(S + 5);
        chk("R2", lower_armed, 1'b0);
        pulse_target(); cyc(S + 3);
        // R8: sticky fault
        ovp_over = 1'b1; cyc(1); ovp_over = 1'b0; cyc(5);
        chk("R8", ovp_fault, 1'b1);
        // R1: shutdown drops power-good at once
        chk("R1", pwr_good, 1'b1);
        en = 1'b0; #1;
        chk("R1", pwr_good, 1'b0);
        cyc(3);
        chk("R1", ovp_fault, 1'b0);
        en = 1'b1; cyc(4);
        comparing = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule